// File: doc/BRIEF.md
# Interrupt Active-State Register Bank

This block keeps the active flag of every interrupt handled by a multi-processor interrupt distributor. Software changes those flags through two byte-wide write windows. In one window a 1 bit marks an interrupt active. In the other window a 1 bit marks it inactive. Reading either window returns the current flags. The first 32 interrupts are private to each processor, so each CPU has its own copy of their flags. All higher interrupts share one flag that every CPU sees.

An access carries a byte offset, eight data bits, write and read strobes, the index of the CPU making the access, and a secure flag. When the security extension is on, a non-secure write cannot touch an interrupt whose group bit is 0. A write or read beyond the implemented interrupts is refused and raises a one-cycle error. On any revision other than 2, writes to the set window are refused as well. Read data and error are registered and appear in the cycle after the access. The active vectors are driven straight from the state flops.

Top module: `irq_active_bank`

## Requirements
- R1: Offsets 0x300–0x37F are the set window and 0x380–0x3FF are the clear window. Byte offset k within a window covers interrupts 8k to 8k+7, and data bit i maps to interrupt 8k+i.
- R2: A write is accepted when its first interrupt is below NUM_IRQ and, for the set window, REVISION equals 2. For an accepted write, each 1 bit sets (set window) or clears (clear window) the addressed active flag from the next cycle on. Each 0 bit leaves its flag unchanged. With no write strobe, no flag changes.
- R3: When `sec_ext_en` is 1 and `acc_secure` is 0, a bit that addresses an interrupt whose `irq_group` bit is 0 is ignored. The other bits of the same byte still take effect.
- R4: A write to interrupts 0–31 changes only the copy of the CPU given by `acc_cpu`. A write to interrupts 32 and above changes the shared flag.
- R5: A write whose first interrupt is at or above NUM_IRQ changes no flag, and `acc_err` is 1 in the following cycle.
- R6: When REVISION is not 2, a write to the set window changes no flag and raises `acc_err` in the following cycle. Clear-window writes still work normally.
- R7: An access with an offset outside 0x300–0x3FF changes nothing. In the following cycle `acc_err` stays 0 and `acc_rdata` is 0.
- R8: A read in either window places, in the following cycle, the 8 flags of the addressed byte on `acc_rdata`, bit i holding interrupt 8k+i as seen by `acc_cpu`. When no valid read happened in the previous cycle, `acc_rdata` is 0.
- R9: A read whose first interrupt is at or above NUM_IRQ returns 0 and raises `acc_err` in the following cycle.
- R10: Reset clears every banked and shared active flag, `acc_rdata` and `acc_err`.
- R11: When a read and a write occur in the same cycle, the read returns the flags as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_offset | input | 10 | Byte offset of the access |
| acc_wdata | input | 8 | Write data, one bit per interrupt |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_cpu | input | CPU_W | Index of the accessing CPU |
| acc_secure | input | 1 | 1 for a secure access |
| sec_ext_en | input | 1 | Security extension enable |
| irq_group | input | NUM_IRQ | Group bit per interrupt |
| acc_rdata | output | 8 | Read data, valid the cycle after a read |
| acc_err | output | 1 | One-cycle error for a refused access |
| banked_active | output | NUM_CPU*32 | Private flags, CPU c at bits [c*32 +: 32] |
| shared_active | output | NUM_IRQ-32 | Shared flags, bit j is interrupt 32+j |

## Verification
The bench targets the boundary between banked and shared interrupts, which is the byte at offset 4. A design that banked one byte too many, or too few, would leak a private write to other CPUs or hide a shared write from them. The bench also writes bytes that mix group-0 and group-1 interrupts under a non-secure access. A design that dropped the whole byte, or applied all of it, shows up on the read-back.

Three more cases are covered. The first byte past the last implemented interrupt checks the range test, which a wrong comparison would misplace by a byte. A second instance built with a different revision checks that only the set window is refused there. Same-cycle read and write checks that the read returns the old value rather than the new one.

// File: rtl/irq_act_pkg.sv
package irq_act_pkg;
  localparam int OFF_W   = 10;
  localparam int BYTE_W  = 8;
  localparam int PRIV_N  = 32;
  localparam int SPACE_N = 1024;

  // Offsets 0x300..0x3FF: top two offset bits both set
  function automatic logic in_window(input logic [OFF_W-1:0] off);
    return off[OFF_W-1 -: 2] == 2'b11;
  endfunction

  // Lower half of the range is the set window
  function automatic logic is_set_window(input logic [OFF_W-1:0] off);
    return ~off[7];
  endfunction

  // First interrupt covered by the byte
  function automatic logic [OFF_W-1:0] first_irq(input logic [OFF_W-1:0] off);
    return {off[6:0], 3'b000};
  endfunction
endpackage

// File: rtl/irq_act_decode.sv
module irq_act_decode
  import irq_act_pkg::*;
#(
  parameter int NUM_IRQ  = 96,
  parameter int REVISION = 2
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             wr,
  input  logic             rd,
  output logic [OFF_W-1:0] base,
  output logic             set_op,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             err_now
);
  localparam logic [OFF_W:0] NIRQ = OFF_W'(NUM_IRQ);
  localparam logic SET_ALLOWED = (REVISION == 2);

  logic win, oob, wr_bad, rd_bad;

  always_comb begin
    win     = in_window(offset);
    base    = first_irq(offset);
    set_op  = is_set_window(offset);
    oob     = {1'b0, base} >= NIRQ;
    wr_bad  = wr & win & (oob | (set_op & ~SET_ALLOWED));
    rd_bad  = rd & win & oob;
    wr_ok   = wr & win & ~wr_bad;
    rd_ok   = rd & win & ~oob;
    err_now = wr_bad | rd_bad;
  end
endmodule

// File: rtl/irq_act_gate.sv
module irq_act_gate
  import irq_act_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic [OFF_W-1:0]   base,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               sec_ext_en,
  input  logic               secure,
  input  logic [NUM_IRQ-1:0] group,
  output logic [BYTE_W-1:0]  eff
);
  logic [SPACE_N+BYTE_W-1:0] grp_ext;
  logic [BYTE_W-1:0]         grp_byte;
  logic                      restrict_g0;

  always_comb begin
    grp_ext     = '1;
    grp_ext[NUM_IRQ-1:0] = group;
    grp_byte    = grp_ext[base +: BYTE_W];
    restrict_g0 = sec_ext_en & ~secure;
    eff         = restrict_g0 ? (wdata & grp_byte) : wdata;
  end
endmodule

// File: rtl/irq_act_store.sv
module irq_act_store
  import irq_act_pkg::*;
#(
  parameter int NUM_IRQ = 96,
  parameter int NUM_CPU = 2,
  parameter int CPU_W   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      apply,
  input  logic                      set_op,
  input  logic [OFF_W-1:0]          base,
  input  logic [BYTE_W-1:0]         eff,
  input  logic [CPU_W-1:0]          cpu,
  output logic [NUM_CPU*PRIV_N-1:0] banked,
  output logic [NUM_IRQ-PRIV_N-1:0] shared
);
  localparam int SH_N = NUM_IRQ - PRIV_N;

  logic [6:0] byte_sel;
  assign byte_sel = base[OFF_W-1:3];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar n = 0; n < PRIV_N; n++) begin : g_bit
      localparam logic [6:0] BIDX = 7'(n / 8);
      logic hit;
      assign hit = apply && (byte_sel == BIDX) && eff[n % 8] && (cpu == CPU_W'(c));
      always_ff @(posedge clk) begin
        if (!rst_n)   banked[c*PRIV_N+n] <= 1'b0;
        else if (hit) banked[c*PRIV_N+n] <= set_op;
      end
    end
  end

  for (genvar k = 0; k < SH_N; k++) begin : g_sh
    localparam logic [6:0] BIDX = 7'((k + PRIV_N) / 8);
    logic hit;
    assign hit = apply && (byte_sel == BIDX) && eff[k % 8];
    always_ff @(posedge clk) begin
      if (!rst_n)   shared[k] <= 1'b0;
      else if (hit) shared[k] <= set_op;
    end
  end
endmodule

// File: rtl/irq_active_bank.sv
module irq_active_bank
  import irq_act_pkg::*;
#(
  parameter int NUM_IRQ  = 96,
  parameter int NUM_CPU  = 2,
  parameter int REVISION = 2,
  parameter int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [9:0]                acc_offset,
  input  logic [7:0]                acc_wdata,
  input  logic                      acc_wr,
  input  logic                      acc_rd,
  input  logic [CPU_W-1:0]          acc_cpu,
  input  logic                      acc_secure,
  input  logic                      sec_ext_en,
  input  logic [NUM_IRQ-1:0]        irq_group,
  output logic [7:0]                acc_rdata,
  output logic                      acc_err,
  output logic [NUM_CPU*32-1:0]     banked_active,
  output logic [NUM_IRQ-32-1:0]     shared_active
);
  // Named internal events, observed by the bound checker
  logic [OFF_W-1:0]  base;
  logic              set_op, wr_apply, rd_ok, err_now;
  logic [BYTE_W-1:0] eff_mask;

  irq_act_decode #(.NUM_IRQ(NUM_IRQ), .REVISION(REVISION)) u_dec (
    .offset(acc_offset), .wr(acc_wr), .rd(acc_rd), .base(base),
    .set_op(set_op), .wr_ok(wr_apply), .rd_ok(rd_ok), .err_now(err_now)
  );

  irq_act_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
    .base(base), .wdata(acc_wdata), .sec_ext_en(sec_ext_en),
    .secure(acc_secure), .group(irq_group), .eff(eff_mask)
  );

  irq_act_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_store (
    .clk(clk), .rst_n(rst_n), .apply(wr_apply), .set_op(set_op), .base(base),
    .eff(eff_mask), .cpu(acc_cpu), .banked(banked_active), .shared(shared_active)
  );

  // Read view for the accessing CPU
  logic [PRIV_N-1:0]          own_bank;
  logic [SPACE_N+BYTE_W-1:0]  view;
  logic [BYTE_W-1:0]          rbyte;

  always_comb begin
    own_bank = '0;
    for (int c = 0; c < NUM_CPU; c++)
      if (acc_cpu == CPU_W'(c)) own_bank = banked_active[c*PRIV_N +: PRIV_N];
    view = '0;
    view[PRIV_N-1:0] = own_bank;
    view[NUM_IRQ-1:PRIV_N] = shared_active;
    rbyte = view[base +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      acc_rdata <= rd_ok ? rbyte : '0;
      acc_err   <= err_now;
    end
  end
endmodule

// File: rtl/irq_active_bank_chk.sv
module irq_active_bank_chk
  import irq_act_pkg::*;
#(
  parameter int NUM_IRQ  = 96,
  parameter int NUM_CPU  = 2,
  parameter int REVISION = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [9:0]            acc_offset,
  input logic                  acc_wr,
  input logic                  acc_rd,
  input logic [7:0]            acc_rdata,
  input logic                  acc_err,
  input logic [NUM_CPU*32-1:0] banked_active,
  input logic [NUM_IRQ-33:0]   shared_active,
  input logic                  wr_apply
);
  localparam logic [10:0] NIRQ = 11'(NUM_IRQ);
  localparam logic REV_OK = (REVISION == 2);

  logic win, oob, low_byte;
  assign win      = in_window(acc_offset);
  assign oob      = {1'b0, first_irq(acc_offset)} >= NIRQ;
  assign low_byte = first_irq(acc_offset) < 10'd32;

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> ($stable(banked_active) && $stable(shared_active)));

  assert_shared_write_spares_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_apply && !low_byte) |=> $stable(banked_active));

  assert_bank_write_spares_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_apply && low_byte) |=> $stable(shared_active));

  assert_oob_write_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && win && oob) |=> (acc_err && $stable(banked_active) && $stable(shared_active)));

  assert_set_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!REV_OK && acc_wr && win && is_set_window(acc_offset))
      |=> (acc_err && $stable(banked_active) && $stable(shared_active)));

  assert_outside_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_wr || acc_rd) && !win) |=> (!acc_err && acc_rdata == 8'h00));

  assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && win && oob) |=> (acc_err && acc_rdata == 8'h00));
endmodule

bind irq_active_bank irq_active_bank_chk #(
  .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .REVISION(REVISION)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_offset(acc_offset), .acc_wr(acc_wr),
  .acc_rd(acc_rd), .acc_rdata(acc_rdata), .acc_err(acc_err),
  .banked_active(banked_active), .shared_active(shared_active),
  .wr_apply(wr_apply)
);

// File: tb/irq_active_bank_tb.sv
module irq_active_bank_tb;
  localparam int NIRQ = 96;
  localparam int NCPU = 3;
  localparam int CW   = 2;
  localparam int SHN  = NIRQ - 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [9:0]      drv_off = '0;
  logic [7:0]      drv_data = '0;
  logic            drv_wr = 1'b0, drv_rd = 1'b0, drv_sec = 1'b1, drv_ext = 1'b0;
  logic [CW-1:0]   drv_cpu = '0;
  logic [NIRQ-1:0] drv_grp = '1;

  logic [7:0]         rdata, rdata1;
  logic               err, err1;
  logic [NCPU*32-1:0] bank, bank1;
  logic [SHN-1:0]     sh, sh1;

  irq_active_bank #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .REVISION(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_offset(drv_off), .acc_wdata(drv_data),
    .acc_wr(drv_wr), .acc_rd(drv_rd), .acc_cpu(drv_cpu), .acc_secure(drv_sec),
    .sec_ext_en(drv_ext), .irq_group(drv_grp), .acc_rdata(rdata), .acc_err(err),
    .banked_active(bank), .shared_active(sh));

  irq_active_bank #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU), .REVISION(1)) u_dut_r1 (
    .clk(clk), .rst_n(rst_n), .acc_offset(drv_off), .acc_wdata(drv_data),
    .acc_wr(drv_wr), .acc_rd(drv_rd), .acc_cpu(drv_cpu), .acc_secure(drv_sec),
    .sec_ext_en(drv_ext), .irq_group(drv_grp), .acc_rdata(rdata1), .acc_err(err1),
    .banked_active(bank1), .shared_active(sh1));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Behavioural reference model
  bit       m_bank [NCPU][32];
  bit       m_sh [SHN];
  bit [7:0] m_rd;
  bit       m_err;

  function automatic bit m_view(int cpu, int n);
    if (n < 32) return (cpu < NCPU) ? m_bank[cpu][n] : 1'b0;
    return m_sh[n-32];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_bank[c, n]) m_bank[c][n] = 1'b0;   // R10
      foreach (m_sh[k]) m_sh[k] = 1'b0;
      m_rd = 8'h00; m_err = 1'b0;
    end else begin
      int base;
      bit inwin, setw;
      inwin = (int'(drv_off) >= 'h300);
      setw  = (int'(drv_off) < 'h380);
      base  = (int'(drv_off) % 128) * 8;
      m_rd = 8'h00; m_err = 1'b0;
      if (drv_rd && inwin) begin                    // R8, R9, R11
        if (base >= NIRQ) m_err = 1'b1;
        else for (int i = 0; i < 8; i++) m_rd[i] = m_view(int'(drv_cpu), base + i);
      end
      if (drv_wr && inwin) begin                    // R2..R6
        if (base >= NIRQ) m_err = 1'b1;
        else for (int i = 0; i < 8; i++) begin
          int n;
          n = base + i;
          if (!drv_data[i]) continue;
          if (drv_ext && !drv_sec && !drv_grp[n]) continue;
          if (n < 32) begin
            if (int'(drv_cpu) < NCPU) m_bank[int'(drv_cpu)][n] = setw;
          end else m_sh[n-32] = setw;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCPU*32-1:0] eb;
      logic [SHN-1:0]     es;
      for (int c = 0; c < NCPU; c++)
        for (int n = 0; n < 32; n++) eb[c*32+n] = m_bank[c][n];
      for (int k = 0; k < SHN; k++) es[k] = m_sh[k];
      if (bank != eb) check(1'b0, "R4 banked_active", 0, 0);
      if (sh != es) check(1'b0, "R2 shared_active", 0, 0);
      check(rdata == m_rd, "R8 acc_rdata", int'(rdata), int'(m_rd));
      check(err == m_err, "R5 acc_err", int'(err), int'(m_err));
    end
  end

  task automatic acc(input bit w, input bit r, input int off, input int data,
                     input int cpu, input bit sec);
    @(negedge clk);
    drv_wr = w; drv_rd = r; drv_off = 10'(off); drv_data = 8'(data);
    drv_cpu = CW'(cpu); drv_sec = sec;
    @(negedge clk);
    drv_wr = 1'b0; drv_rd = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: everything clear after reset
    check(bank == '0 && sh == '0 && rdata == 0 && err == 0, "R10 reset state", int'(bank[31:0]), 0);

    // R4 + R8: banked set for CPU 1, invisible to CPU 0
    acc(1, 0, 'h300, 'h81, 1, 1);
    acc(0, 1, 'h300, 0, 1, 1);
    check(rdata == 8'h81, "R8 cpu1 banked read", rdata, 'h81);
    acc(0, 1, 'h300, 0, 0, 1);
    check(rdata == 8'h00, "R4 cpu0 sees own copy", rdata, 0);

    // R1: byte 11 bit 2 is interrupt 90, shared bit 58
    acc(1, 0, 'h30B, 'h04, 2, 1);
    check(sh[58] == 1'b1, "R1 byte/bit mapping", sh[58], 1);
    acc(0, 1, 'h38B, 0, 0, 1);
    check(rdata == 8'h04, "R1 clear-window read", rdata, 'h04);

    // R4: boundary byte 4 (interrupts 32..39) is shared
    acc(1, 0, 'h304, 'hFF, 0, 1);
    acc(0, 1, 'h304, 0, 2, 1);
    check(rdata == 8'hFF, "R4 shared seen by all", rdata, 'hFF);
    // R2: zeros leave bits, ones clear
    acc(1, 0, 'h384, 'h0F, 1, 1);
    acc(0, 1, 'h304, 0, 0, 1);
    check(rdata == 8'hF0, "R2 clear ones only", rdata, 'hF0);

    // R3: non-secure write, group-0 interrupts 40..43 masked
    drv_ext = 1'b1; drv_grp[43:40] = 4'h0;
    acc(1, 0, 'h305, 'hFF, 0, 0);
    acc(0, 1, 'h305, 0, 0, 1);
    check(rdata == 8'hF0, "R3 group0 ignored", rdata, 'hF0);
    acc(1, 0, 'h305, 'h0F, 0, 1);
    acc(0, 1, 'h305, 0, 0, 1);
    check(rdata == 8'hFF, "R3 secure may write", rdata, 'hFF);
    drv_ext = 1'b0;

    // R5: first byte past the last interrupt
    acc(1, 0, 'h300 + NIRQ/8, 'hFF, 0, 1);
    check(err == 1'b1, "R5 oob write err", err, 1);
    acc(1, 0, 'h300 + NIRQ/8 - 1, 'h80, 0, 1);
    check(err == 1'b0 && sh[NIRQ-33] == 1'b1, "R5 last byte accepted", err, 0);

    // R9: out-of-range read
    acc(0, 1, 'h380 + NIRQ/8, 0, 0, 1);
    check(err == 1'b1 && rdata == 8'h00, "R9 oob read", rdata, 0);

    // R7: outside window
    acc(1, 1, 'h2FF, 'hFF, 0, 1);
    check(err == 1'b0 && rdata == 8'h00, "R7 outside window", rdata, 0);

    // R6: revision-1 instance refuses set window, clear still works
    acc(1, 0, 'h306, 'hFF, 0, 1);
    check(err1 == 1'b1 && sh1 == '0, "R6 set refused", err1, 1);
    acc(1, 0, 'h386, 'hFF, 0, 1);
    check(err1 == 1'b0, "R6 clear accepted", err1, 0);

    // R11: read and write same cycle return old value
    acc(1, 1, 'h301, 'h3C, 2, 1);
    check(rdata == 8'h00, "R11 read before write", rdata, 0);
    acc(0, 1, 'h301, 0, 2, 1);
    check(rdata == 8'h3C, "R11 write landed", rdata, 'h3C);

    // Mixed sequence under model comparison
    for (int j = 0; j < 200; j++)
      acc(j % 3 != 0, j % 2 == 0, 'h300 + (j * 37) % 256, (j * 73) % 256, j % 4, j % 5 != 0);

    // R10: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(bank == '0 && sh == '0, "R10 reset clears", int'(sh[31:0]), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule